// File: doc/BRIEF.md
# Security Region Lock Sequencer

This block is the command logic that guards a small one-time-lockable security region of a parallel NOR-style flash. It watches qualified bus write cycles (an address and a data byte). When the reset pin is held at an elevated level for a settling time, it accepts a two-write protect sequence that sets a permanent lock bit. A read at a fixed address pattern then reports whether the region is locked. The sequence is closed by releasing the elevated level, issuing a reset command and finally a two-write exit command that returns the device to normal array read mode.

The elevated reset level is a digital flag (`rst_hv`). The settling delay (about 1 us) is counted in clock cycles. Driving the reset pin low aborts whatever step is in progress. The lock bit is loaded only by its power-on value and can only be set, so it survives every functional reset and every command.

Top module: `sec_lock_seq`

## Requirements
- R1: While `rst_n` is low, the block enters array read mode and `rd_data` becomes 00h one edge later. `lock_o` is not changed.
- R2: The setup write (data 60h, any address) is accepted only when `rst_hv` is high and `rst_hv` has been high for at least SETTLE_CYC rising edges with `rst_n` high. A setup write that arrives earlier is ignored.
- R3: In setup mode, a write of 40h to an address with bit 6 = 0, bit 1 = 1 and bit 0 = 0 sets `lock_o` at the same edge and enters verify mode.
- R4: In setup mode, any other write drops to read mode and leaves `lock_o` unchanged. This includes a different data byte, or 40h to an address that fails the pattern.
- R5: A read (`rd_en`) at an address with bit 6 = 0, bit 1 = 1 and bit 0 = 0 returns {7'b0, lock} on `rd_data` after the next edge, if the block is in verify mode or security-region mode. A read at any other address, or any read in read mode, returns 00h.
- R6: Once set, `lock_o` stays 1 through hardware resets and through every command sequence.
- R7: In verify mode, the reset command F0h is ignored while `rst_hv` is high. After `rst_hv` is released, F0h moves the block to security-region mode. Any other byte in verify mode drops the block to read mode.
- R8: In security-region mode, the exit sequence is 90h followed by 00h, and it returns the block to read mode. A byte other than 00h after 90h keeps the block in security-region mode. All other writes in that mode are ignored.
- R9: A low `rst_n` aborts setup, verify and security-region modes, and the block returns to read mode.
- R10: Dropping `rst_hv` clears the settle count. In setup mode, it also returns the block to read mode, and the write in that cycle is ignored.
- R11: `rd_data` is registered. It changes only at an edge where `rd_en` is high or `rst_n` is low, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset pin logic level, low aborts to read mode |
| rst_hv | input | 1 | Reset pin held at elevated level |
| wr_en | input | 1 | Qualified write cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data, registered |
| lock_o | output | 1 | Permanent lock status |

## Verification
The protect sequence is driven with several kinds of stimulus:
- a setup byte that arrives before the settle count expires, which separates gated entry from free entry;
- a wrong byte, and 40h at an address that fails the pattern, which separate abort-to-read from staying armed;
- a drop of the elevated level in the middle of setup;
- a full, correct sequence.

Reads at matching and non-matching addresses in each mode show which mode the block is in. These reads show whether it returned 01h or 00h, so the reset command sent before and after the level release, and the exit pair with both a correct and a wrong second byte, can be told apart. Hardware reset pulses after locking show that the lock persists while the mode is lost.

// File: rtl/sls_pkg.sv
package sls_pkg;

  typedef enum logic [2:0] {
    ST_READ   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_VERIFY = 3'd2,
    ST_REGION = 3'd3,
    ST_EXIT1  = 3'd4
  } sls_state_e;

  localparam logic [7:0] CMD_SETUP   = 8'h60;
  localparam logic [7:0] CMD_PROTECT = 8'h40;
  localparam logic [7:0] CMD_RESET   = 8'hF0;
  localparam logic [7:0] CMD_EXIT_A  = 8'h90;
  localparam logic [7:0] CMD_EXIT_B  = 8'h00;

  // address pattern of the lock cell: bit6=0, bit1=1, bit0=0
  function automatic logic is_lock_pat(input logic [6:0] low);
    return (~low[6]) & low[1] & (~low[0]);
  endfunction

  // security region is visible to reads in these modes
  function automatic logic region_mapped(input sls_state_e st);
    return (st == ST_VERIFY) || (st == ST_REGION) || (st == ST_EXIT1);
  endfunction

  function automatic logic [7:0] status_byte(input logic lock);
    return {7'b0, lock};
  endfunction

endpackage

// File: rtl/sls_settle.sv
module sls_settle #(
  parameter int SETTLE_CYC = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hv,
  output logic settled
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !hv) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign settled = (cnt_q == CNT_MAX);

  p_cnt_bound_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

  p_cnt_clear_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    !hv |=> (cnt_q == '0));

endmodule

// File: rtl/sls_cmd_fsm.sv
module sls_cmd_fsm
  import sls_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hv,
  input  logic              settled,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output sls_state_e        state,
  output logic              protect_evt
);
  sls_state_e st_q, st_d;

  logic wr_pat;
  logic unused_wr_addr;
  assign wr_pat = is_lock_pat(wr_addr[6:0]);
  assign unused_wr_addr = ^wr_addr;

  logic entry_ok;
  assign entry_ok = wr_en && hv && settled && (wr_data == CMD_SETUP);

  always_comb begin
    st_d        = st_q;
    protect_evt = 1'b0;
    unique case (st_q)
      ST_READ: begin
        if (entry_ok) st_d = ST_SETUP;
      end
      ST_SETUP: begin
        if (!hv) begin
          st_d = ST_READ;
        end else if (wr_en) begin
          if (wr_data == CMD_PROTECT && wr_pat) begin
            st_d        = ST_VERIFY;
            protect_evt = 1'b1;
          end else begin
            st_d = ST_READ;
          end
        end
      end
      ST_VERIFY: begin
        if (wr_en) begin
          if (wr_data == CMD_RESET) begin
            if (!hv) st_d = ST_REGION;
          end else begin
            st_d = ST_READ;
          end
        end
      end
      ST_REGION: begin
        if (wr_en && wr_data == CMD_EXIT_A) st_d = ST_EXIT1;
      end
      ST_EXIT1: begin
        if (wr_en) st_d = (wr_data == CMD_EXIT_B) ? ST_READ : ST_REGION;
      end
      default: st_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_READ;
    else        st_q <= st_d;
  end

  assign state = st_q;

  p_entry_gated_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_READ && !settled) |=> (st_q == ST_READ));

  p_setup_abort_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SETUP && wr_en && hv && wr_data != CMD_PROTECT) |=> (st_q == ST_READ));

  p_reset_cmd_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_VERIFY && hv) |=> (st_q != ST_REGION));

  p_hw_reset_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (st_q == ST_READ));

  p_hv_drop_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SETUP && !hv) |=> (st_q == ST_READ));

  p_exit_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EXIT1 && wr_en && wr_data == CMD_EXIT_B) |=> (st_q == ST_READ));

endmodule

// File: rtl/sls_lock_bit.sv
module sls_lock_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic protect_evt,
  output logic lock
);
  // loaded only by the power-on value; no functional reset reaches it
  logic lock_q = 1'b0;

  always_ff @(posedge clk) begin
    if (protect_evt) lock_q <= 1'b1;
  end

  assign lock = lock_q;

  p_lock_sticky_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  p_lock_set_src_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && !protect_evt) |=> !lock_q);

endmodule

// File: rtl/sls_read_port.sv
module sls_read_port
  import sls_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  sls_state_e        state,
  input  logic              lock,
  output logic [7:0]        rd_data
);
  logic       rd_hit;
  logic [7:0] rd_val;
  logic       unused_rd_addr;

  assign unused_rd_addr = ^rd_addr;
  assign rd_hit = region_mapped(state) && is_lock_pat(rd_addr[6:0]);
  assign rd_val = rd_hit ? status_byte(lock) : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= 8'h00;
    else if (rd_en) rd_data <= rd_val;
  end

  p_rd_hold_r11 : assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  p_rd_readmode_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && state == ST_READ) |=> (rd_data == 8'h00));

  p_rd_upper_zero_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:1] == 7'b0);

endmodule

// File: rtl/sec_lock_seq.sv
module sec_lock_seq
  import sls_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int SETTLE_CYC = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_hv,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              lock_o
);
  // named internal events, visible to assertions
  logic       settled;
  logic       protect_evt;
  sls_state_e state;

  sls_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .hv      (rst_hv),
    .settled (settled)
  );

  sls_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .hv          (rst_hv),
    .settled     (settled),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .state       (state),
    .protect_evt (protect_evt)
  );

  sls_lock_bit u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .protect_evt (protect_evt),
    .lock        (lock_o)
  );

  sls_read_port #(.ADDR_W(ADDR_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .state   (state),
    .lock    (lock_o),
    .rd_data (rd_data)
  );

  p_protect_only_setup_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    protect_evt |-> (state == ST_SETUP && settled));

endmodule

// File: tb/test_sec_lock_seq.sv
module test_sec_lock_seq;
  localparam int AW     = 12;
  localparam int SETTLE = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rst_hv = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          lock_o;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;
  string cur_req = "R1";

  localparam logic [AW-1:0] A_PAT  = 12'h0A2; // bit6=0 bit1=1 bit0=0
  localparam logic [AW-1:0] A_BAD6 = 12'h042; // bit6=1
  localparam logic [AW-1:0] A_OTH  = 12'h003;

  always #4 clk = ~clk;

  sec_lock_seq #(.ADDR_W(AW), .SETTLE_CYC(SETTLE)) i_sec_lock_seq (
    .clk(clk), .rst_n(rst_n), .rst_hv(rst_hv),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .lock_o(lock_o)
  );

  // behavioural reference model: 0 read, 1 setup, 2 verify, 3 region, 4 exit half
  int m_st = 0, m_cnt = 0, m_nst = 0;
  int m_lock = 0, m_rd = 0;
  bit pat_w, pat_r;

  always @(posedge clk) begin
    pat_w = (wr_addr[6] == 1'b0) && (wr_addr[1] == 1'b1) && (wr_addr[0] == 1'b0);
    pat_r = (rd_addr[6] == 1'b0) && (rd_addr[1] == 1'b1) && (rd_addr[0] == 1'b0);
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_rd = 0;
    end else begin
      if (rd_en) m_rd = (m_st >= 2 && pat_r) ? m_lock : 0;
      m_nst = m_st;
      case (m_st)
        0: if (wr_en && wr_data == 8'h60 && rst_hv && m_cnt >= SETTLE) m_nst = 1;
        1: if (!rst_hv) m_nst = 0;
           else if (wr_en) begin
             if (wr_data == 8'h40 && pat_w) begin m_nst = 2; m_lock = 1; end
             else m_nst = 0;
           end
        2: if (wr_en) begin
             if (wr_data == 8'hF0) begin if (!rst_hv) m_nst = 3; end
             else m_nst = 0;
           end
        3: if (wr_en && wr_data == 8'h90) m_nst = 4;
        4: if (wr_en) m_nst = (wr_data == 8'h00) ? 0 : 3;
        default: m_nst = 0;
      endcase
      m_st  = m_nst;
      m_cnt = rst_hv ? ((m_cnt < SETTLE) ? m_cnt + 1 : SETTLE) : 0;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check({cur_req, " model rd_data"}, rd_data, 8'(m_rd));
      check({cur_req, " model lock"}, {7'b0, lock_o}, 8'(m_lock));
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic hw_reset();
    @(negedge clk); rst_n = 1'b0; rst_hv = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    cur_req = "R1";
    check("R1 reset rd_data", rd_data, 8'h00);
    check("R1 reset lock", {7'b0, lock_o}, 8'h00);
    rst_n = 1'b1;
    idle(1);

    cur_req = "R5";
    rd(A_PAT);
    check("R5 read mode pattern read", rd_data, 8'h00);

    cur_req = "R2";
    rst_hv = 1'b1;
    idle(3);
    wr(12'h123, 8'h60);           // too early: ignored
    wr(A_PAT, 8'h40);
    check("R2 early setup ignored", {7'b0, lock_o}, 8'h00);

    cur_req = "R4";
    idle(SETTLE + 2);
    wr(12'h777, 8'h60);
    wr(A_PAT, 8'h55);             // wrong byte -> read mode
    wr(A_PAT, 8'h40);             // in read mode: no effect
    check("R4 wrong byte aborts", {7'b0, lock_o}, 8'h00);
    wr(12'h000, 8'h60);
    wr(A_BAD6, 8'h40);            // bit6 set -> abort
    wr(A_PAT, 8'h40);
    check("R4 wrong address aborts", {7'b0, lock_o}, 8'h00);

    cur_req = "R10";
    wr(12'h000, 8'h60);
    @(negedge clk); rst_hv = 1'b0;
    @(negedge clk); rst_hv = 1'b1;
    wr(A_PAT, 8'h40);
    check("R10 hv drop leaves setup", {7'b0, lock_o}, 8'h00);
    wr(12'h000, 8'h60);           // count restarted: ignored
    wr(A_PAT, 8'h40);
    check("R10 count restarted", {7'b0, lock_o}, 8'h00);

    cur_req = "R3";
    idle(SETTLE + 2);
    wr(12'h000, 8'h60);
    wr(A_PAT, 8'h40);
    check("R3 lock set", {7'b0, lock_o}, 8'h01);

    cur_req = "R5";
    rd(A_PAT);
    check("R5 verify read locked", rd_data, 8'h01);
    rd(A_OTH);
    check("R5 non-pattern read", rd_data, 8'h00);
    idle(2);
    check("R11 rd_data held", rd_data, 8'h00);

    cur_req = "R7";
    wr(A_PAT, 8'hF0);             // hv still high: ignored
    rd(A_PAT);
    check("R7 reset cmd ignored under hv", rd_data, 8'h01);
    @(negedge clk); rst_hv = 1'b0;
    wr(A_PAT, 8'hF0);
    wr(A_PAT, 8'h33);             // region: ignored
    rd(A_PAT);
    check("R7 region mode after release", rd_data, 8'h01);

    cur_req = "R8";
    wr(12'h000, 8'h90);
    wr(12'h000, 8'h12);           // bad second byte: stay in region
    rd(A_PAT);
    check("R8 bad exit stays in region", rd_data, 8'h01);
    wr(12'h000, 8'h90);
    wr(12'h000, 8'h00);
    rd(A_PAT);
    check("R8 exit to read mode", rd_data, 8'h00);

    cur_req = "R6";
    hw_reset();
    check("R6 lock survives reset", {7'b0, lock_o}, 8'h01);
    check("R1 rd_data after reset", rd_data, 8'h00);

    cur_req = "R9";
    rst_hv = 1'b1;
    idle(SETTLE + 2);
    wr(12'h000, 8'h60);
    wr(A_PAT, 8'h40);
    rd(A_PAT);
    check("R9 verify before abort", rd_data, 8'h01);
    hw_reset();
    rd(A_PAT);
    check("R9 reset aborts verify", rd_data, 8'h00);
    check("R6 lock after relock and reset", {7'b0, lock_o}, 8'h01);

    cur_req = "R7";
    rst_hv = 1'b1;
    idle(SETTLE + 2);
    wr(12'h000, 8'h60);
    wr(A_PAT, 8'h40);
    wr(A_PAT, 8'hAA);             // other byte in verify -> read
    rd(A_PAT);
    check("R7 other byte in verify to read", rd_data, 8'h00);

    idle(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule